// File: doc/BRIEF.md
# Oversampling Serial Receiver with Receive FIFO

This block receives asynchronous serial characters on a single `rx` line and queues them for a host. A one-cycle enable, `tick16`, marks each sampling instant at sixteen times the baud rate (the count is the parameter `OVS`). All receiver state moves only on these ticks. A start bit is recognised on a high-to-low step of `rx` between two ticks. Each bit of the frame is then settled by a two-of-three vote over the three samples around its centre.

Finished characters go into a small receive FIFO. The host reads the oldest character on `rd_data` and removes it with a one-cycle `pop`. `flush` discards everything that is stored. If a character arrives while the FIFO is already full, the whole FIFO is emptied and the arriving character is dropped too. A bad stop bit raises a sticky framing-error flag, and the character is still stored. `rx` must already be synchronous to `clk`. Baud-tick generation lies outside this block.

Top module: `uart_rx_fifo`

## Requirements
- R1: A start is detected on a `tick16` cycle in which `rx` is 0 and the previous sample taken on a tick was 1. That detection tick counts as sample 1 of the start bit, and every bit period spans `OVS` (16) ticks from there.
- R2: Each bit value is the majority of samples 7, 8 and 9 of its period (OVS/2-1, OVS/2, OVS/2+1). The other samples have no effect on the result.
- R3: If the voted start bit is 1, the receiver drops back to idle and stores nothing.
- R4: A frame is 1 start bit, 8 data bits with the least significant bit first, and 1 stop bit. The character enters the FIFO at the clock edge of the stop bit's sample-9 tick, so `empty` falls after that tick.
- R5: A voted stop bit of 0 sets `frame_err`, and the character is still stored. `frame_err` stays set until a flush or a reset.
- R6: After a frame ends or a start is rejected, a new start is accepted only after a tick has sampled `rx` high.
- R7: The FIFO holds up to 8 characters and returns them in arrival order on `rd_data`. `empty` is 1 exactly when no character is held.
- R8: A character that completes while 8 are held and no pop is taken empties the FIFO entirely; the new character is lost as well.
- R9: `pop` with an empty FIFO has no effect. A `pop` in the same cycle as a store into a full FIFO removes the oldest character and keeps the new one.
- R10: `flush` empties the FIFO and clears `frame_err`, and it takes priority over a store in the same cycle.
- R11: Changes on `rx` in cycles without `tick16` are ignored.
- R12: After reset the FIFO is empty, `frame_err` is 0 and the receiver is idle and not armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-cycle sampling enable at OVS times the baud rate |
| rx | input | 1 | Serial input, synchronous to clk, idle high |
| pop | input | 1 | Remove the oldest stored character |
| flush | input | 1 | Discard all stored characters and clear the error flag |
| rd_data | output | 8 | Oldest stored character |
| empty | output | 1 | No character stored |
| frame_err | output | 1 | Sticky: a stop bit voted low |

## Verification
The bench builds the block with its defaults: 8-bit characters, an 8-entry FIFO and 16 samples per bit. With these values, filling the FIFO, overflowing it and popping in the same cycle as a store can all be reached within a few dozen frames. Because the centre window then sits at samples 7 to 9, the bench can put random noise on every sample outside the window and flip any single sample inside it, and the received value must not change. Directed frames add two flips inside the window, a rejected start, a bad stop with `rx` held low afterwards, and flushes and pops placed against stores.

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              rx,
  input  logic              pop,
  input  logic              flush,
  output logic [DATA_W-1:0] rd_data,
  output logic              empty,
  output logic              frame_err
);
  localparam int AW       = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW       = $clog2(OVS + 1);
  localparam int BW       = $clog2(DATA_W + 2);
  localparam int MID      = OVS / 2;
  localparam int S_LO     = MID - 1;
  localparam int S_HI     = MID + 1;
  localparam int STOP_IDX = DATA_W + 1;

  logic              busy, armed, v_lo, v_mid, ferr;
  logic [CW-1:0]     smp, n_smp;
  logic [BW-1:0]     bidx, n_bidx;
  logic [DATA_W-1:0] shreg;
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     rp, wp;
  logic [AW:0]       cnt;

  wire wrap   = (smp == CW'(OVS));
  assign n_smp  = wrap ? CW'(1) : smp + CW'(1);
  assign n_bidx = wrap ? bidx + BW'(1) : bidx;

  wire maj    = (v_lo & v_mid) | (v_lo & rx) | (v_mid & rx);
  wire decide = tick16 && busy && (n_smp == CW'(S_HI));
  wire push   = decide && (n_bidx == BW'(STOP_IDX));
  wire full   = (cnt == (AW+1)'(DEPTH));
  wire do_pop = pop && (cnt != '0);
  wire ovf    = push && full && !do_pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      armed <= 1'b0;
      smp   <= '0;
      bidx  <= '0;
      v_lo  <= 1'b0;
      v_mid <= 1'b0;
      shreg <= '0;
    end else if (tick16) begin
      if (!busy) begin
        if (rx) armed <= 1'b1;
        else if (armed) begin
          busy  <= 1'b1;
          armed <= 1'b0;
          smp   <= CW'(1);
          bidx  <= '0;
        end
      end else begin
        smp  <= n_smp;
        bidx <= n_bidx;
        if (n_smp == CW'(S_LO)) v_lo  <= rx;
        if (n_smp == CW'(MID))  v_mid <= rx;
        if (n_smp == CW'(S_HI)) begin
          if (n_bidx == '0) begin
            if (maj) busy <= 1'b0;
          end else if (n_bidx == BW'(STOP_IDX)) begin
            busy <= 1'b0;
          end else begin
            shreg <= {maj, shreg[DATA_W-1:1]};
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush && !ovf) mem[wp] <= shreg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp  <= '0;
      wp  <= '0;
      cnt <= '0;
    end else if (flush || ovf) begin
      rp  <= '0;
      wp  <= '0;
      cnt <= '0;
    end else begin
      if (push)   wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + AW'(1);
      if (do_pop) rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + AW'(1);
      if (push && !do_pop)      cnt <= cnt + (AW+1)'(1);
      else if (!push && do_pop) cnt <= cnt - (AW+1)'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              ferr <= 1'b0;
    else if (flush)          ferr <= 1'b0;
    else if (push && !maj)   ferr <= 1'b1;
  end

  assign rd_data   = mem[rp];
  assign empty     = (cnt == '0);
  assign frame_err = ferr;

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (AW+1)'(DEPTH));

  // R8
  ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !flush) |=> empty);

  // R10
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (empty && !frame_err));

  // R11
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick16 |=> ($stable(busy) && $stable(smp) && $stable(bidx)));

  // R1
  start_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(armed) && !$past(rx) && $past(tick16)));

  // R9
  pop_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !empty && !tick16 && !flush) |=> (cnt == $past(cnt) - (AW+1)'(1)));

  // R9
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !tick16 && !flush) |=> empty);
endmodule

// File: tb/sim_uart_rx_fifo.sv
`timescale 1ns/1ps
module sim_uart_rx_fifo;
  logic       clk = 1'b0, rst_n = 1'b0, tick16 = 1'b0, rx = 1'b1, pop = 1'b0, flush = 1'b0;
  logic [7:0] rd_data;
  logic       empty, frame_err;
  int checks = 0, errors = 0;
  int q[$];
  bit exp_ferr = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_rx_fifo #(.DATA_W(8), .DEPTH(8), .OVS(16)) u0 (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx(rx), .pop(pop), .flush(flush),
    .rd_data(rd_data), .empty(empty), .frame_err(frame_err));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic p);
    @(negedge clk); rx = v; tick16 = 1'b1; pop = p;
    @(negedge clk); tick16 = 1'b0; pop = 1'b0;
  endtask

  function automatic logic [7:0] flip_bit(input logic [7:0] d, input int fb);
    if (fb >= 1 && fb <= 8) return d ^ (8'd1 << (fb - 1));
    return d;
  endfunction

  task automatic send_frame(input logic [7:0] d, input bit stop_ok, input bit noise,
                            input bit pop_at, input int flip2);
    logic [7:0] expb;
    bit probe;
    expb  = flip_bit(d, flip2);
    probe = (q.size() == 0) && !pop_at;
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0);
    for (int b = 0; b < 10; b++) begin
      logic val;
      int fl;
      val = (b == 0) ? 1'b0 : (b == 9) ? logic'(stop_ok) : d[b-1];
      fl  = $urandom % 3;
      for (int s = 1; s <= 16; s++) begin
        logic v;
        v = val;
        if (noise && (s < 7 || s > 9) && !(b == 0 && s == 1) && !(b == 9 && s > 9))
          v = logic'($urandom % 2);
        if (noise && s == 7 + fl) v = !val;
        if (b == flip2 && (s == 7 || s == 9)) v = !val;
        step(v, pop_at && b == 9 && s == 9);
        if (probe && b == 9 && s == 8) chk("R4 store not before stop sample 9", int'(empty), 1);
        if (probe && b == 9 && s == 9) chk("R4 store at stop sample 9", int'(empty), 0);
      end
    end
    if (pop_at && q.size() > 0) void'(q.pop_front());
    if (q.size() == 8) q.delete();
    else q.push_back(int'(expb));
    if (!stop_ok) exp_ferr = 1;
  endtask

  task automatic do_pop();
    @(negedge clk); pop = 1'b1;
    @(negedge clk); pop = 1'b0;
  endtask

  task automatic drain(input string req);
    while (q.size() > 0) begin
      chk(req, int'(empty), 0);
      chk(req, int'(rd_data), q[0]);
      do_pop();
      void'(q.pop_front());
    end
    chk(req, int'(empty), 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12
    chk("R12 empty after reset", int'(empty), 1);
    chk("R12 frame_err after reset", int'(frame_err), 0);

    // R11: rx pulses without tick must not start anything
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); rx = 1'b0;
      @(negedge clk); rx = 1'b1;
    end
    for (int i = 0; i < 40; i++) step(1'b1, 1'b0);
    chk("R11 no store from untimed rx", int'(empty), 1);

    send_frame(8'hA5, 1, 0, 0, -1);
    drain("R4 LSB-first clean frame");

    // R1 R2: random noise outside window, one flip inside
    for (int i = 0; i < 6; i++) send_frame(8'($urandom), 1, 1, 0, -1);
    drain("R1 R2 noisy frames");

    // R2: two flips in window change the bit
    send_frame(8'h5A, 1, 0, 0, 3);
    send_frame(8'h0F, 1, 1, 0, 8);
    drain("R2 two centre flips");

    // R3: short low pulse rejected
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0);
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0);
    for (int i = 0; i < 30; i++) step(1'b1, 1'b0);
    chk("R3 glitch stores nothing", int'(empty), 1);
    send_frame(8'h3C, 1, 0, 0, -1);
    drain("R3 frame after glitch");

    // R5 R6
    send_frame(8'h81, 0, 0, 0, -1);
    chk("R5 frame_err set", int'(frame_err), 1);
    for (int i = 0; i < 40; i++) step(1'b0, 1'b0);
    send_frame(8'h42, 1, 0, 0, -1);
    chk("R5 frame_err sticky", int'(frame_err), int'(exp_ferr));
    drain("R6 no restart while rx low");

    // R10
    send_frame(8'h11, 1, 1, 0, -1);
    send_frame(8'h22, 1, 1, 0, -1);
    send_frame(8'h33, 0, 0, 0, -1);
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    q.delete(); exp_ferr = 0;
    chk("R10 flush empties", int'(empty), 1);
    chk("R10 flush clears frame_err", int'(frame_err), 0);

    // R9: pop on empty ignored
    do_pop();
    chk("R9 pop on empty", int'(empty), 1);
    send_frame(8'h99, 1, 0, 0, -1);
    drain("R9 data after empty pop");

    // R7: fill to 8, order preserved
    for (int i = 0; i < 8; i++) send_frame(8'($urandom), 1, 1, 0, -1);
    drain("R7 arrival order");

    // R8: overflow clears
    for (int i = 0; i < 8; i++) send_frame(8'($urandom), 1, 1, 0, -1);
    chk("R8 full not empty", int'(empty), 0);
    send_frame(8'hEE, 1, 0, 0, -1);
    chk("R8 overflow empties", int'(empty), 1);
    send_frame(8'h7E, 1, 0, 0, -1);
    drain("R8 after overflow");

    // R9: pop with store into full FIFO
    for (int i = 0; i < 8; i++) send_frame(8'($urandom), 1, 0, 0, -1);
    send_frame(8'hC3, 1, 1, 1, -1);
    drain("R9 pop with store when full");

    chk("R5 frame_err final", int'(frame_err), int'(exp_ferr));
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule